// File: doc/BRIEF.md
# Sync-Triggered Frame Capture

This block cuts a parallel sample stream into frames. It waits for a chosen edge on one of two sync inputs, the horizontal or the vertical sync. It can then search the stream for a 16-bit marker word, compared under a bit mask. After the trigger, and after the marker if one is used, it passes a fixed number of valid samples to its output. Each output beat carries flags that mark where a unit starts and where it ends. The marker search can also accept the bit-inverted marker. The search gives up after a programmable number of samples, and the block then waits for a new trigger.

Several frames can be joined into one output unit. The unit start flag is set only on the first sample of the unit, and the end flag only on the last. Two modes set how the frames after the first one begin. In the first mode, each frame needs its own trigger and marker. In the second, the remaining frames follow straight on from the first. All settings are plain inputs. They are used live, and they may change only while capture is disabled. Output beats appear one clock after the input sample that produced them.

Top module: `sync_frame_capture`

## Requirements
- R1: After reset, `out_valid`, `out_start` and `out_end` are 0. No sample is passed until `enable` is high and a trigger edge has been seen.
- R2: `cfg_trig_vsync` = 0 takes the trigger from `in_hsync` and 1 takes it from `in_vsync`. Edges on the other line have no effect.
- R3: `cfg_trig_fall` = 0 triggers on a 0→1 change of the selected line and 1 triggers on a 1→0 change. A change in the other direction has no effect. The sample in the trigger cycle is not captured.
- R4: With `cfg_mark_mask` = 0, the frame is made of the valid samples that follow the trigger cycle. Cycles with `in_valid` low are skipped. Each captured sample appears on `out_data` with `out_valid` one clock later. `out_start` is set on the first beat of a unit and `out_end` on its last. Both flags are only ever set together with `out_valid`.
- R5: A frame holds `cfg_frame_len` valid samples, and a value of 0 is treated as 1.
- R6: With a non-zero mask, the frame starts after a valid sample d with (d & mask) == (marker & mask). The marker sample itself is not passed to the output.
- R7: With `cfg_inv_check` = 1, a sample with (d & mask) == (~marker & mask) also counts as a match. With `cfg_inv_check` = 0, such a sample is a non-match.
- R8: With `cfg_wait_limit` = L > 0, if none of the first L valid samples after the trigger matches, the block returns to waiting for a trigger. With L = 0 it waits without limit.
- R9: `cfg_agg_frames` = N > 0 joins N frames into one unit. In that case `out_start` is set only on the first beat of frame 0 and `out_end` only on the last beat of frame N−1. With `cfg_agg_mark_first` = 0, each frame needs its own trigger and marker.
- R10: With N > 0 and `cfg_agg_mark_first` = 1, frames 1 to N−1 follow frame 0 back to back, with no trigger and no marker.
- R11: With N > 0 and `cfg_agg_plain_first` = 1, frame 0 of a unit starts only on a non-inverted match. The later frames still accept the inverted marker.
- R12: After the end beat of a unit, the block waits for a new trigger edge. Valid samples without a trigger produce no output.
- R13: Driving `enable` low aborts a capture at once. The beat in that cycle and all later beats are dropped, and a unit cut short carries no end flag. When `enable` returns high, a fresh trigger starts a new unit with `out_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enable | input | 1 | Capture enable; low forces idle |
| cfg_trig_vsync | input | 1 | Trigger line select: 0 horizontal, 1 vertical sync |
| cfg_trig_fall | input | 1 | Trigger edge: 0 rising, 1 falling |
| cfg_frame_len | input | 16 | Samples per frame (0 treated as 1) |
| cfg_agg_frames | input | 16 | Frames per unit, 0 = no joining |
| cfg_agg_mark_first | input | 1 | When joining, only frame 0 waits for trigger and marker |
| cfg_agg_plain_first | input | 1 | When joining, frame 0 needs a non-inverted match |
| cfg_mark_mask | input | 16 | Marker compare mask, 0 = no marker search |
| cfg_mark_word | input | 16 | Marker value |
| cfg_inv_check | input | 1 | Also accept the bit-inverted marker |
| cfg_wait_limit | input | 32 | Valid samples allowed for the marker search, 0 = no limit |
| in_valid | input | 1 | Sample strobe |
| in_data | input | 16 | Sample data |
| in_hsync | input | 1 | Horizontal sync level |
| in_vsync | input | 1 | Vertical sync level |
| out_valid | output | 1 | Output beat valid |
| out_data | output | 16 | Output sample |
| out_start | output | 1 | First beat of a unit |
| out_end | output | 1 | Last beat of a unit |

## Verification
The bound checks on the marker-search counter, the sample counter and the frame counter assume that the settings stay fixed while `enable` is high. The stimulus changes settings only after `enable` has been low for two cycles, and it raises `enable` again only after that. The checks also assume the sync inputs change only between clock edges, so the stimulus moves every input at the falling edge. The bench chooses masks with at least two set bits, so that a sample meant as a non-match cannot also be an inverted match.

// File: rtl/sfc_pkg.sv
// Shared types for the sync-triggered frame capture block.
// Assumes nothing beyond a single clock domain.
package sfc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_WAIT_TRIG = 2'd1,
        ST_WAIT_MARK = 2'd2,
        ST_CAPTURE   = 2'd3
    } sfc_state_e;
endpackage

// File: rtl/sfc_edge_trig.sv
// Edge finder for the two sync lines. Picks one line and one edge direction
// and pulses hit for one cycle on that edge.
// Assumes the sync inputs are already synchronous to clk.
module sfc_edge_trig (
    input  logic clk,
    input  logic rst_n,
    input  logic line_h,
    input  logic line_v,
    input  logic sel_v,
    input  logic fall,
    output logic hit
);
    logic prev_h, prev_v;
    logic cur_l, prev_l;

    // Keep the previous level of both lines on every cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_h <= 1'b0;
            prev_v <= 1'b0;
        end else begin
            prev_h <= line_h;
            prev_v <= line_v;
        end
    end

    // Select the line and compare the current level with the previous one
    always_comb begin
        cur_l  = sel_v ? line_v : line_h;
        prev_l = sel_v ? prev_v : prev_h;
        hit    = fall ? (prev_l & ~cur_l) : (~prev_l & cur_l);
    end
endmodule

// File: rtl/sfc_marker_match.sv
// Masked marker comparator. Reports a match on the plain marker and,
// when allowed, on its bit inverse.
// Assumes a zero mask means marker search is off (active = 0).
module sfc_marker_match #(
    parameter int W = 16
) (
    input  logic [W-1:0] sample,
    input  logic [W-1:0] mask,
    input  logic [W-1:0] word,
    input  logic         inv_en,
    input  logic         plain_only,
    output logic         active,
    output logic         hit
);
    logic plain_eq, inv_eq;

    // Compare under mask against the marker and against its inverse
    always_comb begin
        active   = |mask;
        plain_eq = ((sample ^ word) & mask) == '0;
        inv_eq   = ((sample ^ ~word) & mask) == '0;
        hit      = active & (plain_eq | (inv_en & ~plain_only & inv_eq));
    end
endmodule

// File: rtl/sfc_ctrl.sv
// Capture sequencer: idle, wait for trigger, wait for marker, capture.
// Counts samples per frame and frames per unit, runs the marker timeout,
// and registers the output beat with its start and end flags.
// Assumes the settings are stable while enable is high.
module sfc_ctrl
    import sfc_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int LEN_W  = 16,
    parameter int AGG_W  = 16,
    parameter int WAIT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              trig_hit,
    input  logic              mark_en,
    input  logic              mark_hit,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic [AGG_W-1:0]  cfg_agg,
    input  logic              cfg_mark_first,
    input  logic              cfg_plain_first,
    input  logic [WAIT_W-1:0] cfg_limit,
    output logic              plain_only,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_start,
    output logic              out_end
);
    localparam logic [LEN_W-1:0]  LEN_ONE  = LEN_W'(1);
    localparam logic [AGG_W-1:0]  AGG_ONE  = AGG_W'(1);
    localparam logic [WAIT_W-1:0] WAIT_ONE = WAIT_W'(1);

    sfc_state_e        state;
    logic [LEN_W-1:0]  scnt;
    logic [AGG_W-1:0]  fcnt;
    logic [WAIT_W-1:0] wcnt;
    logic agg_on, last_frame, last_samp, fire, timeout;

    // Decode frame and unit boundaries from the counters
    always_comb begin
        agg_on     = |cfg_agg;
        last_frame = !agg_on || (fcnt == cfg_agg - AGG_ONE);
        last_samp  = (cfg_len <= LEN_ONE) || (scnt == cfg_len - LEN_ONE);
        fire       = enable && (state == ST_CAPTURE) && in_valid;
        timeout    = (cfg_limit != '0) && (wcnt == cfg_limit - WAIT_ONE);
        plain_only = agg_on && cfg_plain_first && (fcnt == '0);
    end

    // Register the output beat and its unit flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_start <= 1'b0;
            out_end   <= 1'b0;
        end else begin
            out_valid <= fire;
            out_data  <= in_data;
            out_start <= fire && (fcnt == '0) && (scnt == '0);
            out_end   <= fire && last_samp && last_frame;
        end
    end

    // Sequence the states and step the counters
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            state <= ST_IDLE;
            scnt  <= '0;
            fcnt  <= '0;
            wcnt  <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    state <= ST_WAIT_TRIG;
                end
                ST_WAIT_TRIG: begin
                    if (trig_hit) begin
                        wcnt  <= '0;
                        state <= mark_en ? ST_WAIT_MARK : ST_CAPTURE;
                    end
                end
                ST_WAIT_MARK: begin
                    if (in_valid) begin
                        if (mark_hit) begin
                            wcnt  <= '0;
                            state <= ST_CAPTURE;
                        end else if (timeout) begin
                            wcnt  <= '0;
                            state <= ST_WAIT_TRIG;
                        end else begin
                            wcnt <= wcnt + WAIT_ONE;
                        end
                    end
                end
                default: begin
                    if (in_valid) begin
                        if (last_samp) begin
                            scnt <= '0;
                            if (last_frame) begin
                                fcnt  <= '0;
                                state <= ST_WAIT_TRIG;
                            end else begin
                                fcnt  <= fcnt + AGG_ONE;
                                state <= cfg_mark_first ? ST_CAPTURE : ST_WAIT_TRIG;
                            end
                        end else begin
                            scnt <= scnt + LEN_ONE;
                        end
                    end
                end
            endcase
        end
    end

    // R13
    abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> state == ST_IDLE);

    // R12
    end_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_end |-> state == ST_WAIT_TRIG);

    // R4
    flags_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_start || out_end) |-> out_valid);

    // R8
    wait_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_MARK && cfg_limit != '0) |-> wcnt < cfg_limit);

    // R5
    samp_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CAPTURE && cfg_len != '0) |-> scnt < cfg_len);

    // R9
    frame_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_agg != '0) |-> fcnt < cfg_agg);
endmodule

// File: rtl/sync_frame_capture.sv
// Top of the sync-triggered frame capture block: joins the edge finder,
// the marker comparator and the capture sequencer.
// Assumes settings change only while enable is low.
module sync_frame_capture #(
    parameter int DATA_W = 16,
    parameter int LEN_W  = 16,
    parameter int AGG_W  = 16,
    parameter int WAIT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              cfg_trig_vsync,
    input  logic              cfg_trig_fall,
    input  logic [LEN_W-1:0]  cfg_frame_len,
    input  logic [AGG_W-1:0]  cfg_agg_frames,
    input  logic              cfg_agg_mark_first,
    input  logic              cfg_agg_plain_first,
    input  logic [DATA_W-1:0] cfg_mark_mask,
    input  logic [DATA_W-1:0] cfg_mark_word,
    input  logic              cfg_inv_check,
    input  logic [WAIT_W-1:0] cfg_wait_limit,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_hsync,
    input  logic              in_vsync,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_start,
    output logic              out_end
);
    logic trig_hit, mark_en, mark_hit, plain_only;

    sfc_edge_trig u_trig (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_h (in_hsync),
        .line_v (in_vsync),
        .sel_v  (cfg_trig_vsync),
        .fall   (cfg_trig_fall),
        .hit    (trig_hit)
    );

    sfc_marker_match #(.W(DATA_W)) u_mark (
        .sample     (in_data),
        .mask       (cfg_mark_mask),
        .word       (cfg_mark_word),
        .inv_en     (cfg_inv_check),
        .plain_only (plain_only),
        .active     (mark_en),
        .hit        (mark_hit)
    );

    sfc_ctrl #(
        .DATA_W (DATA_W),
        .LEN_W  (LEN_W),
        .AGG_W  (AGG_W),
        .WAIT_W (WAIT_W)
    ) u_ctrl (
        .clk             (clk),
        .rst_n           (rst_n),
        .enable          (enable),
        .in_valid        (in_valid),
        .in_data         (in_data),
        .trig_hit        (trig_hit),
        .mark_en         (mark_en),
        .mark_hit        (mark_hit),
        .cfg_len         (cfg_frame_len),
        .cfg_agg         (cfg_agg_frames),
        .cfg_mark_first  (cfg_agg_mark_first),
        .cfg_plain_first (cfg_agg_plain_first),
        .cfg_limit       (cfg_wait_limit),
        .plain_only      (plain_only),
        .out_valid       (out_valid),
        .out_data        (out_data),
        .out_start       (out_start),
        .out_end         (out_end)
    );

    // R3
    trig_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_hit |-> ((cfg_trig_vsync ? in_vsync : in_hsync) == !cfg_trig_fall));
endmodule

// File: tb/sync_frame_capture_test.sv
module sync_frame_capture_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic c_sel = 1'b0, c_fall = 1'b0, c_mfirst = 1'b0, c_plain = 1'b0, c_inv = 1'b0;
    logic [15:0] c_len = 16'd4, c_agg = 16'd0, c_mask = 16'd0, c_word = 16'd0;
    logic [31:0] c_limit = 32'd0;
    logic iv = 1'b0, hs = 1'b0, vs = 1'b0;
    logic [15:0] id = 16'd0;
    logic ov, os, oe;
    logic [15:0] od;

    int errors = 0;
    int checks = 0;
    logic [17:0] exp_q[$];
    logic [17:0] got_q[$];

    always #2 clk = ~clk;

    sync_frame_capture uut (
        .clk(clk), .rst_n(rst_n), .enable(en),
        .cfg_trig_vsync(c_sel), .cfg_trig_fall(c_fall),
        .cfg_frame_len(c_len), .cfg_agg_frames(c_agg),
        .cfg_agg_mark_first(c_mfirst), .cfg_agg_plain_first(c_plain),
        .cfg_mark_mask(c_mask), .cfg_mark_word(c_word),
        .cfg_inv_check(c_inv), .cfg_wait_limit(c_limit),
        .in_valid(iv), .in_data(id), .in_hsync(hs), .in_vsync(vs),
        .out_valid(ov), .out_data(od), .out_start(os), .out_end(oe)
    );

    // Collect output beats away from the active edge
    always @(negedge clk) if (rst_n && ov) got_q.push_back({os, oe, od});

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL R1 watchdog: actual=hung expected=finished");
        summary();
        $finish;
    end

    task automatic step(input logic v, input logic [15:0] d);
        iv = v; id = d;
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, expv);
        end
    endtask

    function automatic logic [15:0] pick_plain();
        return (16'($urandom) & ~c_mask) | (c_word & c_mask);
    endfunction
    function automatic logic [15:0] pick_inv();
        return (16'($urandom) & ~c_mask) | (~c_word & c_mask);
    endfunction
    function automatic logic [15:0] pick_miss();
        logic [15:0] low = c_mask & (~c_mask + 16'd1);
        return (16'($urandom) & ~c_mask) | ((c_word ^ low) & c_mask);
    endfunction

    task automatic stop();
        en = 1'b0;
        step(0, 0); step(0, 0);
    endtask

    task automatic go();
        hs = c_fall; vs = c_fall;
        en = 1'b1;
        step(0, 0); step(0, 0);
    endtask

    // Put lines at the pre-edge level; junk samples must not be captured
    task automatic arm();
        hs = c_fall; vs = c_fall;
        step(1, 16'($urandom));
        step(0, 0);
    endtask

    // Selected-edge cycle, carrying a valid sample that must not be captured
    task automatic trig();
        if (c_sel) vs = ~c_fall; else hs = ~c_fall;
        step(1, 16'($urandom));
    endtask

    task automatic frame(input int len, input bit s_unit, input bit e_unit);
        int eff = (len == 0) ? 1 : len;
        for (int i = 0; i < eff; i++) begin
            logic [15:0] d = 16'($urandom);
            if ($urandom % 4 == 0) step(0, 16'($urandom));
            step(1, d);
            exp_q.push_back({s_unit && i == 0, e_unit && i == eff - 1, d});
        end
    endtask

    task automatic compare(input string req);
        step(0, 0); step(0, 0); step(0, 0);
        check({req, " beat count"}, got_q.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
            check({req, " beat"}, {14'd0, got_q[i]}, {14'd0, exp_q[i]});
        exp_q.delete();
        got_q.delete();
    endtask

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk);
        step(0, 0); step(0, 0);
        check("R1 out_valid at reset", ov, 0);
        check("R1 out_start at reset", os, 0);
        check("R1 out_end at reset", oe, 0);
        rst_n = 1'b1;
        step(1, 16'h1111); step(1, 16'h2222);
        compare("R1 no output while disabled");

        // R2 R3 R4: rising edge on hsync; vsync edges ignored
        c_sel = 0; c_fall = 0; c_len = 16'd4;
        hs = 1'b1; vs = 1'b0;
        en = 1'b1; step(0, 0); step(0, 0);
        hs = 1'b0; step(1, 16'hAAAA); step(1, 16'hBBBB);   // R3 wrong direction
        vs = 1'b1; step(1, 16'hCCCC); vs = 1'b0; step(1, 16'hDDDD); // R2 other line
        trig();
        frame(4, 1, 1);
        step(1, 16'h1234); step(1, 16'h5678);              // R12 no new trigger
        compare("R2 R3 R4 R12 directed hsync");

        // R5: zero length treated as one sample
        stop(); c_len = 16'd0; go();
        arm(); trig(); frame(0, 1, 1);
        step(1, 16'h0F0F);
        compare("R5 zero length");

        // R2 R3 R5: random line, edge and length
        for (int it = 0; it < 12; it++) begin
            stop();
            c_sel = 1'($urandom); c_fall = 1'($urandom); c_len = 16'(1 + $urandom % 8);
            go();
            arm(); trig();
            frame(int'(c_len), 1, 1);
            step(1, 16'($urandom));
            compare("R2 R3 R5 random trigger");
        end

        // R6 R7: marker search, random mask and marker
        for (int it = 0; it < 10; it++) begin
            stop();
            c_sel = 0; c_fall = 0; c_len = 16'(1 + $urandom % 5); c_limit = 0;
            c_mask = 16'($urandom) | 16'h0101; c_word = 16'($urandom);
            c_inv = 1'($urandom);
            go();
            arm(); trig();
            for (int k = 0; k < int'($urandom % 4); k++) step(1, pick_miss());
            if (c_inv && ($urandom % 2 == 0)) step(1, pick_inv());
            else begin
                if (!c_inv) step(1, pick_inv());                   // R7 inverse ignored
                step(1, pick_plain());
            end
            frame(int'(c_len), 1, 1);
            compare("R6 R7 marker match");
        end

        // R8: timeout after L misses, then boundary match, then unlimited
        stop();
        c_len = 16'd3; c_mask = 16'hFF00; c_word = 16'h5A00; c_inv = 0; c_limit = 32'd3;
        go();
        arm(); trig();
        step(1, pick_miss()); step(1, pick_miss()); step(1, pick_miss());
        step(1, pick_plain());
        step(1, 16'h0001); step(1, 16'h0002); step(1, 16'h0003);
        compare("R8 timeout cancels");
        arm(); trig();
        step(1, pick_miss()); step(1, pick_miss()); step(1, pick_plain());
        frame(3, 1, 1);
        compare("R8 match on last allowed sample");
        stop(); c_limit = 0; go();
        arm(); trig();
        for (int k = 0; k < 40; k++) step(1, pick_miss());
        step(1, pick_plain());
        frame(3, 1, 1);
        compare("R8 zero limit waits");

        // R9: three frames per unit, each re-triggered
        stop();
        c_mask = 0; c_limit = 0; c_len = 16'd3; c_agg = 16'd3; c_mfirst = 0;
        go();
        arm(); trig(); frame(3, 1, 0);
        arm(); trig(); frame(3, 0, 0);
        arm(); trig(); frame(3, 0, 1);
        arm(); trig(); frame(3, 1, 0);
        compare("R9 joined frames");

        // R10: back-to-back frames after one trigger
        stop(); c_agg = 16'd3; c_mfirst = 1; c_len = 16'd2; go();
        arm(); trig();
        frame(2, 1, 0); frame(2, 0, 0); frame(2, 0, 1);
        step(1, 16'h7777); step(1, 16'h8888);
        compare("R10 back to back");

        // R11: frame 0 needs plain marker, frame 1 accepts inverse
        stop();
        c_agg = 16'd2; c_mfirst = 0; c_plain = 1; c_inv = 1; c_len = 16'd2;
        c_mask = 16'h0FF0; c_word = 16'h0A50;
        go();
        arm(); trig();
        step(1, pick_inv()); step(1, pick_plain());
        frame(2, 1, 0);
        arm(); trig();
        step(1, pick_inv());
        frame(2, 0, 1);
        compare("R11 plain first frame");

        // R13: abort mid-frame, then a fresh unit
        stop();
        c_agg = 0; c_plain = 0; c_inv = 0; c_mask = 0; c_len = 16'd6;
        go();
        arm(); trig();
        frame(3, 1, 0);
        en = 1'b0; step(1, 16'hDEAD); step(1, 16'hBEEF);
        en = 1'b1; step(0, 0); step(1, 16'hCAFE); step(1, 16'hF00D);
        arm(); trig();
        frame(6, 1, 1);
        compare("R13 abort and restart");

        summary();
        $finish;
    end
endmodule